// File: doc/BRIEF.md
# Serial Flash Status and Block-Protect Unit

This unit is the status and protection core of a serial flash slave. It keeps a write-enable latch, two block-protect bits and a protect-enable bit. It answers read-status and read-ID commands with a registered byte. It accepts write-status commands and starts an internal write cycle for them. It also judges whether a program or erase address lies inside the locked top-of-array region.

A command decoder in front of it presents one-cycle strobes, a data byte and an address. An internal sequencer reports a busy level while a timed write runs. The block returns the byte to be shifted out, a write-allowed flag for each program or erase request, and a start pulse for each accepted write-status command.

The parameter `FOUR_SECT` selects the array. A value of 1 gives a 128 KB array in four sectors. A value of 0 gives a 64 KB array in two sectors. The device code and the reset values of the protect bits are also parameters.

Top module: `sflash_stat_prot`

## Requirements
- R1: After reset `dout` is 0x00, `wr_ok` and `wcyc_start` are 0, and the write-enable latch is clear. The protect bits and the protect-enable bit take their reset parameters, which default to 0.
- R2: When the device is not busy, a read-status strobe makes `dout` show the following fields on the next cycle: bit 0 = 0, bit 1 = write-enable latch, bit 2 = BP0, bit 3 = BP1, bits 6..4 = 0, bit 7 = protect-enable. `dout` keeps its value while no read strobe arrives.
- R3: A read-status strobe while `wr_busy` is high makes `dout` read 0xFF on the next cycle.
- R4: A write-enable strobe sets the latch only while not busy. A write-disable strobe clears it. When both strobes arrive in one cycle, the latch is cleared.
- R5: The latch is cleared in the cycle after `wr_busy` falls, and a write-enable strobe arriving in that same cycle is overridden.
- R6: A write-status strobe is accepted only when the latch is set and the device is not busy. An accepted strobe loads BP0, BP1 and protect-enable from `din` bits 2, 3 and 7 and raises `wcyc_start` for the next cycle. A strobe that is not accepted changes nothing and gives no pulse.
- R7: A read-ID strobe makes `dout` 0x1F on the next cycle. The next ID-advance strobe returns the device-code parameter. Later ID-advance strobes return 0x00.
- R8: With `FOUR_SECT`=1, only address bits 16..0 are decoded. BP1:BP0 = 00 locks nothing. 01 locks the addresses whose bits 16..15 are 11. 10 locks the addresses whose bit 16 is 1. 11 locks every address.
- R9: With `FOUR_SECT`=0, only BP1:BP0 = 11 locks, and it locks every address. Levels 01 and 10 lock nothing.
- R10: One cycle after a program strobe, `wr_ok` equals latch set AND not busy AND address not locked. In every other cycle `wr_ok` is 0, and a program strobe leaves the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wren_stb | input | 1 | Write-enable command strobe |
| wrdi_stb | input | 1 | Write-disable command strobe |
| rdsr_stb | input | 1 | Read-status command strobe |
| wrsr_stb | input | 1 | Write-status command strobe |
| rdid_stb | input | 1 | Read-ID command strobe |
| idnext_stb | input | 1 | Advance to the next ID byte |
| prog_stb | input | 1 | Program/erase permission request |
| din | input | 8 | Data byte for write-status |
| addr | input | ADDR_W | Target address of the program/erase request |
| wr_busy | input | 1 | Internal write cycle in progress |
| dout | output | 8 | Registered read-back byte |
| wr_ok | output | 1 | Program/erase allowed, one cycle after the request |
| wcyc_start | output | 1 | Pulse that starts the internal write cycle for a write-status |

## Verification
Corrupted latch or protect state cannot be seen directly at the ports. It appears either on the next read-status byte, one cycle after the strobe, or as a wrong `wr_ok` one cycle after a program request. The stimulus therefore interleaves these reads and requests with every state-changing command. A stale busy edge detector would leave the latch set after a write cycle, and the next status read would show bit 1 still high. A wrong lock decode shows up as an inverted `wr_ok` for addresses near the quarter and half boundaries. Both array sizes run side by side on the same stimulus.

// File: rtl/sfsp_pkg.sv
package sfsp_pkg;
  localparam logic [7:0] SFSP_MFR_CODE = 8'h1F;

  typedef struct packed {
    logic       wpen;
    logic [1:0] bp;
    logic       wel;
  } sfsp_state_t;

  function automatic logic [7:0] sfsp_status_byte(input sfsp_state_t s, input logic busy);
    if (busy) return 8'hFF;
    return {s.wpen, 3'b000, s.bp, s.wel, 1'b0};
  endfunction
endpackage

// File: rtl/sfsp_ctrl.sv
module sfsp_ctrl
  import sfsp_pkg::*;
#(
  parameter logic [1:0] BP_RST   = 2'b00,
  parameter logic       WPEN_RST = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wren_stb,
  input  logic        wrdi_stb,
  input  logic        wrsr_stb,
  input  logic [7:0]  din,
  input  logic        wr_busy,
  output sfsp_state_t st,
  output logic        wcyc_start
);
  localparam int BP0_POS  = 2;
  localparam int BP1_POS  = 3;
  localparam int WPEN_POS = 7;

  logic busy_q;
  logic wr_done;
  logic wrsr_take;

  assign wr_done   = busy_q && !wr_busy;
  assign wrsr_take = wrsr_stb && st.wel && !wr_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      st.wel     <= 1'b0;
      st.bp      <= BP_RST;
      st.wpen    <= WPEN_RST;
      wcyc_start <= 1'b0;
    end else begin
      busy_q     <= wr_busy;
      wcyc_start <= wrsr_take;
      if (wr_done || wrdi_stb)
        st.wel <= 1'b0;
      else if (wren_stb && !wr_busy)
        st.wel <= 1'b1;
      if (wrsr_take) begin
        st.bp   <= {din[BP1_POS], din[BP0_POS]};
        st.wpen <= din[WPEN_POS];
      end
    end
  end

  // R4: no latch set while busy
  a_r4_no_set_busy: assert property (@(posedge clk) disable iff (rst)
    (wr_busy && !st.wel) |=> !st.wel);
  // R4: disable wins
  a_r4_wrdi_clears: assert property (@(posedge clk) disable iff (rst)
    wrdi_stb |=> !st.wel);
  // R5: end of write cycle clears the latch
  a_r5_done_clears: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !wr_busy) |=> !st.wel);
  // R6: a rejected write-status leaves protect bits alone
  a_r6_reject_stable: assert property (@(posedge clk) disable iff (rst)
    (wrsr_stb && !(st.wel && !wr_busy)) |=> (!wcyc_start && $stable(st.bp) && $stable(st.wpen)));
endmodule

// File: rtl/sfsp_readback.sv
module sfsp_readback
  import sfsp_pkg::*;
#(
  parameter logic [7:0] DEV_CODE = 8'h65
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rdsr_stb,
  input  logic        rdid_stb,
  input  logic        idnext_stb,
  input  logic        wr_busy,
  input  sfsp_state_t st,
  output logic [7:0]  dout
);
  typedef enum logic [1:0] {ID_IDLE, ID_MFR, ID_DONE} id_pos_t;
  id_pos_t id_pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout   <= 8'h00;
      id_pos <= ID_IDLE;
    end else if (rdsr_stb) begin
      dout <= sfsp_status_byte(st, wr_busy);
    end else if (rdid_stb) begin
      dout   <= SFSP_MFR_CODE;
      id_pos <= ID_MFR;
    end else if (idnext_stb) begin
      dout   <= (id_pos == ID_MFR) ? DEV_CODE : 8'h00;
      id_pos <= ID_DONE;
    end
  end

  // R3: busy reads all ones
  a_r3_busy_ff: assert property (@(posedge clk) disable iff (rst)
    (rdsr_stb && wr_busy) |=> (dout == 8'hFF));
  // R2: idle status has zero busy flag and zero spare bits
  a_r2_idle_fields: assert property (@(posedge clk) disable iff (rst)
    (rdsr_stb && !wr_busy) |=> (dout[6:4] == 3'b000 && !dout[0]));
  // R7: manufacturer byte first
  a_r7_mfr_first: assert property (@(posedge clk) disable iff (rst)
    (rdid_stb && !rdsr_stb) |=> (dout == SFSP_MFR_CODE));
endmodule

// File: rtl/sfsp_prot.sv
module sfsp_prot #(
  parameter int ADDR_W    = 24,
  parameter bit FOUR_SECT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        bp,
  input  logic              wel,
  input  logic              wr_busy,
  output logic              wr_ok
);
  localparam int ARR_W = FOUR_SECT ? 17 : 16;
  localparam int TOP   = ARR_W - 1;

  logic locked;

  generate
    if (FOUR_SECT) begin : g_four
      always_comb begin
        unique case (bp)
          2'b00:   locked = 1'b0;
          2'b01:   locked = &addr[TOP:TOP-1];
          2'b10:   locked = addr[TOP];
          default: locked = 1'b1;
        endcase
      end
    end else begin : g_two
      assign locked = &bp;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) wr_ok <= 1'b0;
    else     wr_ok <= prog_stb && wel && !wr_busy && !locked;
  end

  // R10: flag only follows a request
  a_r10_needs_req: assert property (@(posedge clk) disable iff (rst)
    wr_ok |-> $past(prog_stb));
  // R8/R9: full lock blocks everything
  a_r8_full_lock: assert property (@(posedge clk) disable iff (rst)
    (prog_stb && bp == 2'b11) |=> !wr_ok);
  // R8/R9: level zero blocks nothing
  a_r9_no_lock: assert property (@(posedge clk) disable iff (rst)
    (prog_stb && bp == 2'b00 && wel && !wr_busy) |=> wr_ok);
endmodule

// File: rtl/sflash_stat_prot.sv
module sflash_stat_prot
  import sfsp_pkg::*;
#(
  parameter int         ADDR_W    = 24,
  parameter bit         FOUR_SECT = 1'b1,
  parameter logic [7:0] DEV_CODE  = 8'h65,
  parameter logic [1:0] BP_RST    = 2'b00,
  parameter logic       WPEN_RST  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wren_stb,
  input  logic              wrdi_stb,
  input  logic              rdsr_stb,
  input  logic              wrsr_stb,
  input  logic              rdid_stb,
  input  logic              idnext_stb,
  input  logic              prog_stb,
  input  logic [7:0]        din,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_busy,
  output logic [7:0]        dout,
  output logic              wr_ok,
  output logic              wcyc_start
);
  sfsp_state_t st;

  sfsp_ctrl #(.BP_RST(BP_RST), .WPEN_RST(WPEN_RST)) u_ctrl (
    .clk(clk), .rst(rst), .wren_stb(wren_stb), .wrdi_stb(wrdi_stb),
    .wrsr_stb(wrsr_stb), .din(din), .wr_busy(wr_busy),
    .st(st), .wcyc_start(wcyc_start)
  );

  sfsp_readback #(.DEV_CODE(DEV_CODE)) u_rb (
    .clk(clk), .rst(rst), .rdsr_stb(rdsr_stb), .rdid_stb(rdid_stb),
    .idnext_stb(idnext_stb), .wr_busy(wr_busy), .st(st), .dout(dout)
  );

  sfsp_prot #(.ADDR_W(ADDR_W), .FOUR_SECT(FOUR_SECT)) u_prot (
    .clk(clk), .rst(rst), .prog_stb(prog_stb), .addr(addr),
    .bp(st.bp), .wel(st.wel), .wr_busy(wr_busy), .wr_ok(wr_ok)
  );
endmodule

// File: tb/sflash_stat_prot_bench.sv
module sflash_stat_prot_bench;
  localparam logic [7:0] DEV = 8'h65;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wren_stb = 0, wrdi_stb = 0, rdsr_stb = 0, wrsr_stb = 0;
  logic rdid_stb = 0, idnext_stb = 0, prog_stb = 0;
  logic [7:0]  din = 0;
  logic [23:0] addr = 0;
  logic        wr_busy = 0;
  logic [7:0]  dout, dout_s;
  logic        wr_ok, wr_ok_s, wcyc_start, wcyc_start_s;

  int checks = 0;
  int errors = 0;

  logic       m_wel = 0, m_wpen = 0, m_busyq = 0;
  logic [1:0] m_bp = 0;
  int         m_id = 0;
  logic [7:0] e_rd = 0;

  always #10 clk = ~clk;

  sflash_stat_prot #(.FOUR_SECT(1'b1), .DEV_CODE(DEV)) u_sflash_stat_prot (
    .clk(clk), .rst(rst), .wren_stb(wren_stb), .wrdi_stb(wrdi_stb),
    .rdsr_stb(rdsr_stb), .wrsr_stb(wrsr_stb), .rdid_stb(rdid_stb),
    .idnext_stb(idnext_stb), .prog_stb(prog_stb), .din(din), .addr(addr),
    .wr_busy(wr_busy), .dout(dout), .wr_ok(wr_ok), .wcyc_start(wcyc_start));

  sflash_stat_prot #(.FOUR_SECT(1'b0), .DEV_CODE(DEV)) u_sflash_stat_prot_small (
    .clk(clk), .rst(rst), .wren_stb(wren_stb), .wrdi_stb(wrdi_stb),
    .rdsr_stb(rdsr_stb), .wrsr_stb(wrsr_stb), .rdid_stb(rdid_stb),
    .idnext_stb(idnext_stb), .prog_stb(prog_stb), .din(din), .addr(addr),
    .wr_busy(wr_busy), .dout(dout_s), .wr_ok(wr_ok_s), .wcyc_start(wcyc_start_s));

  function automatic logic lock_of(input logic [1:0] bp, input logic [23:0] a, input logic four);
    if (!four) return bp == 2'b11;
    case (bp)
      2'b00: return 1'b0;
      2'b01: return a[16] && a[15];
      2'b10: return a[16];
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  // op: 0 none,1 wren,2 wrdi,3 rdsr,4 wrsr,5 rdid,6 idnext,7 prog,8 wren+wrdi
  task automatic step(input int op, input logic [7:0] d, input logic [23:0] a, input logic b);
    logic e_ok, e_oks, e_st;
    string tag;
    wren_stb   = (op == 1 || op == 8);
    wrdi_stb   = (op == 2 || op == 8);
    rdsr_stb   = (op == 3);
    wrsr_stb   = (op == 4);
    rdid_stb   = (op == 5);
    idnext_stb = (op == 6);
    prog_stb   = (op == 7);
    din = d; addr = a; wr_busy = b;
    tag = "R2";
    if (op == 3) begin
      e_rd = b ? 8'hFF : {m_wpen, 3'b000, m_bp, m_wel, 1'b0};
      tag = b ? "R3" : "R2/R4/R5/R6";
    end else if (op == 5) begin
      e_rd = 8'h1F; m_id = 1; tag = "R7";
    end else if (op == 6) begin
      e_rd = (m_id == 1) ? DEV : 8'h00; m_id = 2; tag = "R7";
    end
    e_ok  = (op == 7) && m_wel && !b && !lock_of(m_bp, a, 1'b1);
    e_oks = (op == 7) && m_wel && !b && !lock_of(m_bp, a, 1'b0);
    e_st  = (op == 4) && m_wel && !b;
    if (m_busyq && !b)               m_wel = 1'b0;
    else if (op == 2 || op == 8)     m_wel = 1'b0;
    else if (op == 1 && !b)          m_wel = 1'b1;
    if (e_st) begin m_bp = d[3:2]; m_wpen = d[7]; end
    m_busyq = b;
    @(negedge clk);
    chk(tag, dout, e_rd);
    chk(tag, dout_s, e_rd);
    chk("R8/R10", {7'b0, wr_ok}, {7'b0, e_ok});
    chk("R9/R10", {7'b0, wr_ok_s}, {7'b0, e_oks});
    chk("R6", {7'b0, wcyc_start}, {7'b0, e_st});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int op;
    logic b;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1", dout, 8'h00);
    chk("R1", {7'b0, wr_ok}, 8'h00);
    chk("R1", {7'b0, wcyc_start}, 8'h00);
    step(3, 0, 0, 0);                 // R1 status defaults
    step(7, 0, 0, 0);                 // R10 no latch, no permission
    step(1, 0, 0, 0); step(3, 0, 0, 0);   // R4 set
    step(8, 0, 0, 0); step(3, 0, 0, 0);   // R4 disable wins
    step(1, 0, 0, 1); step(3, 0, 0, 1);   // R4 ignored busy, R3 0xFF
    step(0, 0, 0, 0); step(3, 0, 0, 0);
    step(4, 8'hFF, 0, 0); step(3, 0, 0, 0);  // R6 rejected without latch
    step(1, 0, 0, 0);
    step(4, 8'h04, 0, 0); step(3, 0, 0, 0);  // R6 level 01
    step(7, 0, 24'h018000, 0);        // R8 locked, R9 open
    step(7, 0, 24'h017FFF, 0);
    step(4, 8'h08, 0, 0);             // level 10
    step(7, 0, 24'h010000, 0);
    step(7, 0, 24'h00FFFF, 0);
    step(4, 8'h8C, 0, 0); step(3, 0, 0, 0);  // level 11 + protect-enable
    step(7, 0, 24'h000000, 0);
    step(4, 8'h00, 0, 1);             // rejected while busy
    step(0, 0, 0, 0); step(3, 0, 0, 0);      // R5 latch dropped at busy fall
    step(6, 0, 0, 0);                 // R7 advance before read-ID
    step(5, 0, 0, 0); step(6, 0, 0, 0); step(6, 0, 0, 0); step(0, 0, 0, 0);
    step(1, 0, 0, 1); step(1, 0, 0, 0); step(3, 0, 0, 0);  // R5 override of wren
    b = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 9) == 0) b = ~b;
      op = $urandom_range(0, 8);
      if (op == 2 && $urandom_range(0, 2) != 0) op = 1;
      step(op, 8'($urandom), {7'b0, 17'($urandom)}, b);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule